// File: doc/BRIEF.md
# ARINC 429 Receive Word Filter and Buffer

This block sits behind a serial ARINC 429 bit receiver. Each time the receiver finishes a 32-bit word it pulses a strobe with the word. The block then decides whether to keep the word. The decision uses two tests. The first is a per-label enable table with 256 entries, which the host loads through a small write port. The second is an optional odd-parity test over all 32 bits. Words that pass go into a 32-deep buffer. The host reads that buffer through a show-ahead data port with a pop strobe.

A control register holds four settings: label bit reversal, parity checking, label filtering, and the source of the interrupt. When label bit reversal is set, the eight label bits are swapped end for end. The swap applies both to the table lookup and to the word that is stored. When parity checking is off, bit 31 is kept unchanged as an ordinary data bit. A status vector reports three buffer conditions: not empty, half full and full. It also carries an overflow flag. The overflow flag stays set until the host reads the status. The interrupt output follows whichever buffer condition the control register selects.

The acceptance path is a four-state machine:
- ST_IDLE waits for the strobe and captures the word.
- ST_JUDGE applies the label and parity tests and folds the label order into the held word.
- ST_STORE pushes the word into the buffer.
- ST_SPILL drops an accepted word because the buffer is full, and raises the overflow flag.

The named transitions are:
- IDLE→JUDGE on the strobe.
- JUDGE→STORE when the word passes and there is room.
- JUDGE→SPILL when the word passes and the buffer is full.
- JUDGE→IDLE when the word is rejected.
- STORE→IDLE and SPILL→IDLE unconditionally.

Top module: `a429_rx_filter`

## Requirements
- R1: Writing `tbl_we` with `tbl_label` and `tbl_bit` sets the enable of that one label. When filtering is on (ctrl bit 2), a word is kept only if the enable of its label is 1. The label is word bits [7:0], after any reversal.
- R2: When filtering is off, words are kept whatever their label, subject only to the parity test.
- R3: When ctrl bit 0 is set, the label is bit-reversed (new bit i = old bit 7-i). The reversed label is used for the lookup and is also written into bits [7:0] of the stored word. Bits [31:8] are stored unchanged.
- R4: When ctrl bit 1 is set, a word whose 32 bits hold an even number of ones is dropped. The drop has no effect on the buffer and does not set overflow.
- R5: When ctrl bit 1 is clear, the parity test is skipped and bit 31 is stored exactly as received.
- R6: The buffer holds 32 words of 32 bits in arrival order. `rd_data` shows the oldest word. `rd_pop` removes that word, and `rd_pop` has no effect when the buffer is empty.
- R7: `stat_flags` bit 0 means the buffer is not empty, bit 1 means it holds 16 or more words, and bit 2 means it holds 32 words. `rx_avail` equals bit 0.
- R8: `irq` follows the condition chosen by ctrl bits [4:3]: 0 selects not empty, 1 selects half full, 2 selects full, and 3 holds `irq` low.
- R9: A word that passes while the buffer is full is dropped and sets `stat_flags` bit 3. The flag clears on a `stat_rd` pulse. If the set and the clear fall in the same cycle, the set wins.
- R10: A strobe is taken only in ST_IDLE. An accepted word shows up at the outputs after the third rising edge counted from the edge that captured it. A strobe in either of the next two cycles is ignored.
- R11: A push and a pop in the same cycle leave the word count unchanged and advance the head of the buffer.
- R12: Reset empties the buffer, clears the overflow flag and all control bits, and sets all 256 label enables to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| word_valid | input | 1 | Pulse: a complete received word is on `word_data` |
| word_data | input | 32 | Received word, label in bits [7:0] |
| tbl_we | input | 1 | Write one label-table entry |
| tbl_label | input | 8 | Label whose enable is written |
| tbl_bit | input | 1 | New enable value |
| ctrl_we | input | 1 | Write the control register |
| ctrl_wdata | input | 5 | {irq select[1:0], filter enable, parity enable, label reverse} |
| rd_pop | input | 1 | Remove the oldest buffered word |
| rd_data | output | 32 | Oldest buffered word (show-ahead) |
| stat_rd | input | 1 | Status read strobe; clears overflow |
| stat_flags | output | 4 | {overflow, full, half full, not empty} |
| rx_avail | output | 1 | Buffer holds at least one word |
| irq | output | 1 | Selected buffer condition |

## Verification
Two pairs of functions can meet in the same cycle. The first pair is a push from ST_STORE and a host pop. The bench provokes it by raising `rd_pop` during the cycle the machine sits in ST_STORE. It then judges that the count stays put and the head moves on to the new word. The second pair is overflow set and overflow clear. The bench pulses `stat_rd` during the ST_SPILL cycle on a full buffer and expects the flag to survive. It then expects a later lone `stat_rd` to clear the flag.

// File: rtl/a429f_pkg.sv
package a429f_pkg;

    localparam int WORD_W = 32;
    localparam int LBL_W  = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_JUDGE,
        ST_STORE,
        ST_SPILL
    } judge_st_t;

    typedef struct packed {
        logic [1:0] irq_sel;
        logic       filt_en;
        logic       par_en;
        logic       lbl_rev;
    } rx_ctrl_t;

    localparam logic [1:0] IRQ_NONEMPTY = 2'd0;
    localparam logic [1:0] IRQ_HALF     = 2'd1;
    localparam logic [1:0] IRQ_FULL     = 2'd2;
    localparam logic [1:0] IRQ_OFF      = 2'd3;

    function automatic logic [LBL_W-1:0] flip_lbl(input logic [LBL_W-1:0] v);
        logic [LBL_W-1:0] r;
        for (int i = 0; i < LBL_W; i++) begin
            r[i] = v[LBL_W-1-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/a429f_label_map.sv
module a429f_label_map #(
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [LW-1:0] wr_lbl,
    input  logic          wr_bit,
    input  logic [LW-1:0] rd_lbl,
    output logic          rd_hit
);
    localparam int ENTRIES = 1 << LW;

    logic [ENTRIES-1:0] en_q;

    // one flop per label, each with its own decode
    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_q[g] <= 1'b0;
            end else if (wr_en && (wr_lbl == LW'(g))) begin
                en_q[g] <= wr_bit;
            end
        end
    end

    assign rd_hit = en_q[rd_lbl];

endmodule

// File: rtl/a429f_fifo.sv
module a429f_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               push_data,
    input  logic                       pop,
    output logic [W-1:0]               head,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign do_pop  = pop && (count != '0);
    assign do_push = push && (count < CW'(DEPTH));

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head = mem[rd_ptr];

endmodule

// File: rtl/a429f_judge.sv
module a429f_judge
    import a429f_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int LW = LBL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          word_valid,
    input  logic [W-1:0]  word_data,
    input  rx_ctrl_t      ctrl,
    input  logic          map_hit,
    input  logic          buf_full,
    output logic [LW-1:0] lkp_lbl,
    output logic          push,
    output logic [W-1:0]  push_data,
    output logic          spill,
    output judge_st_t     st
);
    judge_st_t     st_q, st_d;
    logic [W-1:0]  word_q;
    logic [LW-1:0] lbl_eff;
    logic          par_ok, pass;

    assign lbl_eff = ctrl.lbl_rev ? flip_lbl(word_q[LW-1:0]) : word_q[LW-1:0];
    assign par_ok  = ^word_q;
    assign pass    = (!ctrl.filt_en || map_hit) && (!ctrl.par_en || par_ok);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // word holder: capture in IDLE, fold label order in JUDGE
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (st_q == ST_IDLE && word_valid) begin
            word_q <= word_data;
        end else if (st_q == ST_JUDGE) begin
            word_q <= {word_q[W-1:LW], lbl_eff};
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (word_valid) st_d = ST_JUDGE;
            ST_JUDGE: begin
                if (!pass)         st_d = ST_IDLE;
                else if (buf_full) st_d = ST_SPILL;
                else               st_d = ST_STORE;
            end
            ST_STORE: st_d = ST_IDLE;
            ST_SPILL: st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        push  = 1'b0;
        spill = 1'b0;
        unique case (st_q)
            ST_IDLE:  ;
            ST_JUDGE: ;
            ST_STORE: push  = 1'b1;
            ST_SPILL: spill = 1'b1;
        endcase
    end

    assign lkp_lbl   = lbl_eff;
    assign push_data = word_q;
    assign st        = st_q;

endmodule

// File: rtl/a429_rx_filter.sv
module a429_rx_filter
    import a429f_pkg::*;
#(
    parameter int W     = WORD_W,
    parameter int LW    = LBL_W,
    parameter int DEPTH = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          word_valid,
    input  logic [W-1:0]  word_data,
    input  logic          tbl_we,
    input  logic [LW-1:0] tbl_label,
    input  logic          tbl_bit,
    input  logic          ctrl_we,
    input  logic [4:0]    ctrl_wdata,
    input  logic          rd_pop,
    output logic [W-1:0]  rd_data,
    input  logic          stat_rd,
    output logic [3:0]    stat_flags,
    output logic          rx_avail,
    output logic          irq
);
    localparam int CW   = $clog2(DEPTH+1);
    localparam int HALF = DEPTH / 2;

    rx_ctrl_t      ctrl_q;
    logic          ovf_q;
    logic [CW-1:0] count;
    logic [LW-1:0] lkp_lbl;
    logic          map_hit, push, spill;
    logic [W-1:0]  push_data;
    logic          f_nonempty, f_half, f_full;
    judge_st_t     judge_st;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_we) begin
            ctrl_q <= rx_ctrl_t'(ctrl_wdata);
        end
    end

    // sticky overflow: a new spill outranks the clearing read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else if (spill) begin
            ovf_q <= 1'b1;
        end else if (stat_rd) begin
            ovf_q <= 1'b0;
        end
    end

    a429f_label_map #(.LW(LW)) u_map (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (tbl_we),
        .wr_lbl (tbl_label),
        .wr_bit (tbl_bit),
        .rd_lbl (lkp_lbl),
        .rd_hit (map_hit)
    );

    a429f_judge #(.W(W), .LW(LW)) u_judge (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_valid (word_valid),
        .word_data  (word_data),
        .ctrl       (ctrl_q),
        .map_hit    (map_hit),
        .buf_full   (f_full),
        .lkp_lbl    (lkp_lbl),
        .push       (push),
        .push_data  (push_data),
        .spill      (spill),
        .st         (judge_st)
    );

    a429f_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (push_data),
        .pop       (rd_pop),
        .head      (rd_data),
        .count     (count)
    );

    assign f_nonempty = (count != '0);
    assign f_half     = (count >= CW'(HALF));
    assign f_full     = (count == CW'(DEPTH));
    assign stat_flags = {ovf_q, f_full, f_half, f_nonempty};
    assign rx_avail   = f_nonempty;

    always_comb begin
        irq = 1'b0;
        unique case (ctrl_q.irq_sel)
            IRQ_NONEMPTY: irq = f_nonempty;
            IRQ_HALF:     irq = f_half;
            IRQ_FULL:     irq = f_full;
            IRQ_OFF:      irq = 1'b0;
        endcase
    end

endmodule

// File: rtl/a429f_chk.sv
module a429f_chk
    import a429f_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input logic                       clk,
    input logic                       rst_n,
    input judge_st_t                  st,
    input logic [$clog2(DEPTH+1)-1:0] count,
    input logic                       push,
    input logic                       rd_pop,
    input logic                       spill,
    input logic                       stat_rd,
    input logic [3:0]                 stat_flags,
    input logic [4:0]                 ctrl_wdata,
    input logic                       irq
);
    localparam int CW = $clog2(DEPTH+1);

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R6

    AST_PUSH_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> count < CW'(DEPTH)); // R9

    AST_PUSH_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (push && rd_pop && count != '0) |=> $stable(count)); // R11

    AST_SPILL_SETS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        spill |=> stat_flags[3]); // R9

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_flags[3] && !stat_rd) |=> stat_flags[3]); // R9

    AST_BUSY_IGNORES_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) |=> (st != ST_JUDGE)); // R10

    AST_FULL_NOT_HALF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        stat_flags[2] |-> stat_flags[1]); // R7

    AST_IRQ_EMPTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_flags[0] |-> !irq); // R8

    logic unused_ok;
    assign unused_ok = ^ctrl_wdata;

endmodule

bind a429_rx_filter a429f_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .st         (judge_st),
    .count      (count),
    .push       (push),
    .rd_pop     (rd_pop),
    .spill      (spill),
    .stat_rd    (stat_rd),
    .stat_flags (stat_flags),
    .ctrl_wdata (ctrl_wdata),
    .irq        (irq)
);

// File: tb/sim_a429_rx_filter.sv
module sim_a429_rx_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_valid = 1'b0;
    logic [31:0] word_data = '0;
    logic        tbl_we = 1'b0;
    logic [7:0]  tbl_label = '0;
    logic        tbl_bit = 1'b0;
    logic        ctrl_we = 1'b0;
    logic [4:0]  ctrl_wdata = '0;
    logic        rd_pop = 1'b0;
    logic [31:0] rd_data;
    logic        stat_rd = 1'b0;
    logic [3:0]  stat_flags;
    logic        rx_avail;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    a429_rx_filter u0 (
        .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_data(word_data),
        .tbl_we(tbl_we), .tbl_label(tbl_label), .tbl_bit(tbl_bit),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .rd_pop(rd_pop), .rd_data(rd_data),
        .stat_rd(stat_rd), .stat_flags(stat_flags), .rx_avail(rx_avail), .irq(irq)
    );

    // {ctrl[4:0], word[31:0], kept, stored word[31:0]}
    localparam int NV = 12;
    localparam logic [69:0] VEC [NV] = '{
        {5'b00000, 32'h0000_0030, 1'b1, 32'h0000_0030}, // R5 even word, parity off
        {5'b00110, 32'h8000_0030, 1'b1, 32'h8000_0030}, // R1 R4 enabled, odd
        {5'b00110, 32'h0000_0030, 1'b0, 32'h0000_0000}, // R4 even dropped
        {5'b00110, 32'h0000_0031, 1'b0, 32'h0000_0000}, // R1 label off
        {5'b00010, 32'h0000_0031, 1'b1, 32'h0000_0031}, // R2 filter off
        {5'b00111, 32'h8000_000C, 1'b1, 32'h8000_0030}, // R3 reversed lookup+store
        {5'b00111, 32'h8000_0030, 1'b0, 32'h0000_0000}, // R3 reversed 0x0C off
        {5'b00111, 32'h1234_56A5, 1'b1, 32'h1234_56A5}, // R3 palindrome label
        {5'b00100, 32'h0000_0030, 1'b1, 32'h0000_0030}, // R5 filter on, parity off
        {5'b00101, 32'h0000_0003, 1'b0, 32'h0000_0000}, // R3 0xC0 off
        {5'b00110, 32'h7FFF_FFFF, 1'b1, 32'h7FFF_FFFF}, // R1 label FF
        {5'b00101, 32'h0000_00FF, 1'b1, 32'h0000_00FF}  // R3 R5
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_ctrl(input logic [4:0] v);
        @(negedge clk) ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk) ctrl_we = 1'b0;
    endtask

    task automatic set_lbl(input logic [7:0] l, input logic b);
        @(negedge clk) tbl_we = 1'b1; tbl_label = l; tbl_bit = b;
        @(negedge clk) tbl_we = 1'b0;
    endtask

    // strobe at N0; optional second strobe at N1; stat_rd / rd_pop during the store cycle
    task automatic send(input logic [31:0] d, input logic dup, input logic rd2, input logic pop2);
        @(negedge clk) word_valid = 1'b1; word_data = d;
        @(negedge clk) word_valid = dup; word_data = ~d;
        @(negedge clk) word_valid = 1'b0; stat_rd = rd2; rd_pop = pop2;
        @(negedge clk) stat_rd = 1'b0; rd_pop = 1'b0;
        @(negedge clk);
    endtask

    task automatic pop1;
        @(negedge clk) rd_pop = 1'b1;
        @(negedge clk) rd_pop = 1'b0;
    endtask

    task automatic status_read;
        @(negedge clk) stat_rd = 1'b1;
        @(negedge clk) stat_rd = 1'b0;
    endtask

    initial begin
        #400000;
        n_bad++;
        n_cmp++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check("R12 flags", {28'b0, stat_flags}, 32'h0);
        check("R7 rx_avail", {31'b0, rx_avail}, 32'h0);
        check("R8 irq", {31'b0, irq}, 32'h0);

        set_lbl(8'h30, 1'b1);
        set_lbl(8'hA5, 1'b1);
        set_lbl(8'hFF, 1'b1);

        for (int i = 0; i < NV; i++) begin
            set_ctrl(VEC[i][69:65]);
            send(VEC[i][64:33], 1'b0, 1'b0, 1'b0);
            check($sformatf("R1-vec%0d kept", i), {31'b0, rx_avail}, {31'b0, VEC[i][32]});
            check("R4 no overflow", {31'b0, stat_flags[3]}, 32'h0);
            if (VEC[i][32]) begin
                check($sformatf("R3-vec%0d data", i), rd_data, VEC[i][31:0]);
                pop1();
            end
        end

        // R1 clearing an enable
        set_lbl(8'h30, 1'b0);
        set_ctrl(5'b00110);
        send(32'h8000_0030, 1'b0, 1'b0, 1'b0);
        check("R1 disabled label", {31'b0, rx_avail}, 32'h0);

        // R10 latency and busy strobe ignored
        set_ctrl(5'b00000);
        @(negedge clk) word_valid = 1'b1; word_data = 32'hCAFE_0001;
        @(negedge clk) word_valid = 1'b1; word_data = 32'hDEAD_0002;
        @(negedge clk) word_valid = 1'b0;
        check("R10 not yet", {31'b0, rx_avail}, 32'h0);
        @(negedge clk);
        check("R10 arrived", {31'b0, rx_avail}, 32'h1);
        check("R10 data", rd_data, 32'hCAFE_0001);
        pop1();
        repeat (3) @(negedge clk);
        check("R10 dup ignored", {31'b0, rx_avail}, 32'h0);

        // R6 R7 R8 fill
        set_ctrl(5'b01000);
        for (int k = 0; k < 32; k++) begin
            send(32'h100 + k, 1'b0, 1'b0, 1'b0);
            if (k == 14) check("R7 half low at 15", {31'b0, stat_flags[1]}, 32'h0);
            if (k == 15) begin
                check("R7 half at 16", {31'b0, stat_flags[1]}, 32'h1);
                check("R8 irq half", {31'b0, irq}, 32'h1);
            end
            if (k == 30) check("R7 full low at 31", {31'b0, stat_flags[2]}, 32'h0);
        end
        check("R7 full", {28'b0, stat_flags}, 32'h7);
        set_ctrl(5'b10000);
        check("R8 irq full", {31'b0, irq}, 32'h1);
        set_ctrl(5'b11000);
        check("R8 irq off", {31'b0, irq}, 32'h0);
        set_ctrl(5'b00000);
        check("R8 irq nonempty", {31'b0, irq}, 32'h1);

        // R9 overflow, set wins over a read in the spill cycle
        send(32'hBAD0_0000, 1'b0, 1'b1, 1'b0);
        check("R9 ovf set", {28'b0, stat_flags}, 32'hF);
        check("R9 head kept", rd_data, 32'h100);
        status_read();
        check("R9 ovf cleared", {31'b0, stat_flags[3]}, 32'h0);

        for (int k = 0; k < 32; k++) begin
            check("R6 order", rd_data, 32'h100 + k);
            pop1();
        end
        check("R6 empty", {31'b0, rx_avail}, 32'h0);
        pop1();
        check("R6 pop on empty", {31'b0, rx_avail}, 32'h0);

        // R11 push and pop in one cycle
        send(32'h0000_0A01, 1'b0, 1'b0, 1'b0);
        send(32'h0000_0A02, 1'b0, 1'b0, 1'b1);
        check("R11 head advanced", rd_data, 32'h0000_0A02);
        pop1();
        check("R11 count kept", {31'b0, rx_avail}, 32'h0);

        // R12 reset mid-run
        set_lbl(8'h30, 1'b1);
        set_ctrl(5'b00110);
        send(32'h8000_0030, 1'b0, 1'b0, 1'b0);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        check("R12 buffer cleared", {28'b0, stat_flags}, 32'h0);
        send(32'h0000_0030, 1'b0, 1'b0, 1'b0);
        check("R12 ctrl cleared", {31'b0, rx_avail}, 32'h1);
        pop1();
        set_ctrl(5'b00100);
        send(32'h0000_0030, 1'b0, 1'b0, 1'b0);
        check("R12 map cleared", {31'b0, rx_avail}, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule